// File: doc/BRIEF.md
# IOTLB Invalidation Command Decoder

This block sits between a command queue and a translation cache whose entries are labelled with the kind of translation that produced them. It takes one invalidation command made of two 64-bit words and turns it into one or two sweep requests. Each request names a translation-kind tag, a mask that says which identifiers and whether the address must match, and the operand values to compare against. The cache performs each sweep and reports completion. Only then does the decoder issue the next request or take a new command.

A first-stage invalidation targets either single-stage entries or nested entries, depending on whether a guest context is named. A guest-physical invalidation affects both G-stage-only entries and nested entries, so it is issued as two sweeps back to back with an identical mask. A guest-physical command that asks for process-ID matching, or any unknown function code, is rejected. The rejection is a one-cycle error pulse and no sweep is issued.

Top module: `iotinv_decoder`

## Requirements
- R1: `cmd_ready` is high exactly when no command is in progress, and a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. After reset `cmd_ready`=1, `sw_valid`=0 and `cmd_err`=0.
- R2: Command fields in the first word are as follows. Function code is bits [2:0], where 0 is first-stage and 1 is guest-physical. AV is bit 3, PSCV is bit 4 and GV is bit 5. The process ID is bits [31:12] and the guest ID is bits [47:32]. Tag codes are 0 bypass, 1 single-stage, 2 G-stage-only and 3 nested. In the mask, bit 0 means guest ID match, bit 1 means process ID match and bit 2 means address match. A sweep never carries tag 0.
- R3: A first-stage command with GV=0 issues one sweep with tag 1 and mask {AV, PSCV, 0}. With all flags clear, this is a match on tag alone.
- R4: A first-stage command with GV=1 issues one sweep with tag 3 and mask {AV, PSCV, 1}.
- R5: A guest-physical command with PSCV=1, or a command with function code 2 to 7, produces `cmd_err` high for exactly the cycle after acceptance. In that cycle `cmd_ready` is high and no sweep is issued.
- R6: A legal guest-physical command issues a sweep with tag 2 and mask {GV&AV, 0, GV}. In the cycle after that sweep's done, it issues a sweep with tag 3 and the same mask and operands.
- R7: The sweep address is the second word shifted left by 2, with bits [11:0] cleared and truncated to 64 bits. The guest and process operands are the R2 fields.
- R8: A sweep request is presented from the cycle after acceptance. It stays unchanged with `sw_valid` high until `sw_done` is sampled high. One cycle after the last done, `sw_valid` falls and `cmd_ready` rises. `sw_done` has no effect while no sweep is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Decoder idle, command can be taken |
| cmd_dw0 | input | 64 | Command word with function code, flags and IDs |
| cmd_dw1 | input | 64 | Command address word |
| sw_valid | output | 1 | Sweep request active |
| sw_tag | output | 2 | Translation-kind tag to sweep |
| sw_mask | output | 3 | Match enables: guest, process, address |
| sw_gscid | output | 16 | Guest ID operand |
| sw_pscid | output | 20 | Process ID operand |
| sw_addr | output | 64 | Page-aligned address operand |
| sw_done | input | 1 | Cache has finished the active sweep |
| cmd_err | output | 1 | Illegal command pulse |

## Verification
The hardest case to reach is the hand-over inside a guest-physical command. The tag must change while the request stays valid, and that has to hold when the first done comes immediately as well as when it comes after a delay. It also has to hold while the next command is already waiting on `cmd_valid`. The stimulus keeps a command queued behind every one in progress and drives `sw_done` from a pseudo-random sequence that also pulses while idle. Every flag combination of both function codes, and random words, then meet zero-cycle and multi-cycle completions. A behavioural queue model checks ready, valid, error and all request fields on every cycle.

// File: rtl/iotinv_pkg.sv
package iotinv_pkg;

    localparam int FUNC_W    = 3;
    localparam int GSCID_W   = 16;
    localparam int PSCID_W   = 20;
    localparam int ADDR_W    = 64;
    localparam int PG_BITS   = 12;
    localparam int MASK_W    = 3;

    localparam int AV_BIT    = 3;
    localparam int PSCV_BIT  = 4;
    localparam int GV_BIT    = 5;
    localparam int PSCID_LSB = 12;
    localparam int GSCID_LSB = 32;

    localparam logic [FUNC_W-1:0] FN_VMA  = 3'd0;
    localparam logic [FUNC_W-1:0] FN_GVMA = 3'd1;

    localparam int M_GUEST = 0;
    localparam int M_PROC  = 1;
    localparam int M_ADDR  = 2;

    typedef enum logic [1:0] {
        TAG_BYPASS = 2'd0,
        TAG_SINGLE = 2'd1,
        TAG_GSTAGE = 2'd2,
        TAG_NESTED = 2'd3
    } xlat_tag_e;

    typedef struct packed {
        xlat_tag_e            tag;
        logic [MASK_W-1:0]    mask;
        logic [GSCID_W-1:0]   gscid;
        logic [PSCID_W-1:0]   pscid;
        logic [ADDR_W-1:0]    addr;
    } sweep_req_t;

    typedef struct packed {
        logic       illegal;
        logic       two_pass;
        sweep_req_t req;
    } cmd_plan_t;

    function automatic logic [ADDR_W-1:0] page_addr(input logic [ADDR_W-3:0] w);
        logic [ADDR_W-1:0] keep;
        keep = '1;
        keep = keep << PG_BITS;
        return {w, 2'b00} & keep;
    endfunction

endpackage

// File: rtl/iotinv_decode.sv
module iotinv_decode
    import iotinv_pkg::*;
(
    input  logic [63:0] dw0,
    input  logic [63:0] dw1,
    output cmd_plan_t   plan
);

    logic [FUNC_W-1:0] func;
    logic              av, pscv, gv;
    logic              unused_bits;

    assign func        = dw0[FUNC_W-1:0];
    assign av          = dw0[AV_BIT];
    assign pscv        = dw0[PSCV_BIT];
    assign gv          = dw0[GV_BIT];
    assign unused_bits = ^{dw0, dw1};

    always_comb begin
        plan           = '0;
        plan.req.gscid = dw0[GSCID_LSB +: GSCID_W];
        plan.req.pscid = dw0[PSCID_LSB +: PSCID_W];
        plan.req.addr  = page_addr(dw1[ADDR_W-3:0]);
        case (func)
            FN_VMA: begin
                plan.req.tag          = gv ? TAG_NESTED : TAG_SINGLE;
                plan.req.mask[M_GUEST] = gv;
                plan.req.mask[M_PROC]  = pscv;
                plan.req.mask[M_ADDR]  = av;
            end
            FN_GVMA: begin
                if (pscv) begin
                    plan.illegal = 1'b1;
                end else begin
                    plan.two_pass          = 1'b1;
                    plan.req.tag           = TAG_GSTAGE;
                    plan.req.mask[M_GUEST] = gv;
                    plan.req.mask[M_ADDR]  = gv & av;
                end
            end
            default: plan.illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/iotinv_seq.sv
module iotinv_seq
    import iotinv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  cmd_plan_t  plan,
    input  logic       sw_done,
    output logic       cmd_ready,
    output logic       sw_valid,
    output sweep_req_t req,
    output logic       cmd_err
);

    typedef enum logic {ST_IDLE, ST_SWEEP} seq_state_e;

    seq_state_e state_q;
    sweep_req_t req_q;
    logic       pend_q;
    logic       err_q;

    assign cmd_ready = (state_q == ST_IDLE);
    assign sw_valid  = (state_q == ST_SWEEP);
    assign req       = req_q;
    assign cmd_err   = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            pend_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        if (plan.illegal) begin
                            err_q <= 1'b1;
                        end else begin
                            req_q   <= plan.req;
                            pend_q  <= plan.two_pass;
                            state_q <= ST_SWEEP;
                        end
                    end
                end
                ST_SWEEP: begin
                    if (sw_done) begin
                        if (pend_q) begin
                            req_q.tag <= TAG_NESTED;
                            pend_q    <= 1'b0;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R8
    hold_until_done_chk: assert property (@(posedge clk) disable iff (rst)
        sw_valid && !sw_done |=> sw_valid && $stable(req));

    // R6
    second_pass_chk: assert property (@(posedge clk) disable iff (rst)
        sw_valid && sw_done && req.tag == TAG_GSTAGE |=>
        sw_valid && req.tag == TAG_NESTED && $stable(req.mask) && $stable(req.addr)
        && $stable(req.gscid));

    // R1
    ready_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        sw_valid && sw_done && req.tag != TAG_GSTAGE |=> cmd_ready && !sw_valid);

    // R5
    err_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> $past(cmd_valid && cmd_ready) && cmd_ready && !sw_valid);

endmodule

// File: rtl/iotinv_decoder.sv
module iotinv_decoder
    import iotinv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [63:0]        cmd_dw0,
    input  logic [63:0]        cmd_dw1,
    output logic               sw_valid,
    output logic [1:0]         sw_tag,
    output logic [MASK_W-1:0]  sw_mask,
    output logic [GSCID_W-1:0] sw_gscid,
    output logic [PSCID_W-1:0] sw_pscid,
    output logic [ADDR_W-1:0]  sw_addr,
    input  logic               sw_done,
    output logic               cmd_err
);

    cmd_plan_t  plan;
    sweep_req_t req;

    iotinv_decode u_decode (
        .dw0  (cmd_dw0),
        .dw1  (cmd_dw1),
        .plan (plan)
    );

    iotinv_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .plan      (plan),
        .sw_done   (sw_done),
        .cmd_ready (cmd_ready),
        .sw_valid  (sw_valid),
        .req       (req),
        .cmd_err   (cmd_err)
    );

    assign sw_tag   = req.tag;
    assign sw_mask  = req.mask;
    assign sw_gscid = req.gscid;
    assign sw_pscid = req.pscid;
    assign sw_addr  = req.addr;

    // R2
    no_bypass_sweep_chk: assert property (@(posedge clk) disable iff (rst)
        sw_valid |-> sw_tag != TAG_BYPASS);

    // R3
    single_no_guest_chk: assert property (@(posedge clk) disable iff (rst)
        sw_valid && sw_tag == TAG_SINGLE |-> !sw_mask[M_GUEST]);

    // R6
    gstage_mask_chk: assert property (@(posedge clk) disable iff (rst)
        sw_valid && sw_tag == TAG_GSTAGE |->
        !sw_mask[M_PROC] && (!sw_mask[M_ADDR] || sw_mask[M_GUEST]));

    // R7
    page_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        sw_valid |-> sw_addr[PG_BITS-1:0] == '0);

endmodule

// File: tb/iotinv_decoder_bench.sv
module iotinv_decoder_bench;
    import iotinv_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cmd_valid = 1'b0;
    logic               cmd_ready;
    logic [63:0]        cmd_dw0 = '0;
    logic [63:0]        cmd_dw1 = '0;
    logic               sw_valid;
    logic [1:0]         sw_tag;
    logic [MASK_W-1:0]  sw_mask;
    logic [GSCID_W-1:0] sw_gscid;
    logic [PSCID_W-1:0] sw_pscid;
    logic [ADDR_W-1:0]  sw_addr;
    logic               sw_done = 1'b0;
    logic               cmd_err;

    always #5 clk = ~clk;

    iotinv_decoder u_iotinv_decoder (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_dw0(cmd_dw0), .cmd_dw1(cmd_dw1), .sw_valid(sw_valid),
        .sw_tag(sw_tag), .sw_mask(sw_mask), .sw_gscid(sw_gscid),
        .sw_pscid(sw_pscid), .sw_addr(sw_addr), .sw_done(sw_done),
        .cmd_err(cmd_err)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    sweep_req_t exp_q[$];
    logic       exp_err = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", what, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Reference model: expected request queue, advanced at every clock edge
    task automatic model_accept();
        sweep_req_t r;
        logic [2:0] f;
        logic a, p, g;
        f = cmd_dw0[2:0];
        a = cmd_dw0[3];
        p = cmd_dw0[4];
        g = cmd_dw0[5];
        r.gscid = cmd_dw0[47:32];
        r.pscid = cmd_dw0[31:12];
        r.addr  = (cmd_dw1 << 2) & ~64'hFFF;
        if (f == 3'd0) begin
            r.tag  = g ? TAG_NESTED : TAG_SINGLE;
            r.mask = {a, p, g};
            exp_q.push_back(r);
        end else if (f == 3'd1 && !p) begin
            r.mask = {g & a, 1'b0, g};
            r.tag  = TAG_GSTAGE;
            exp_q.push_back(r);
            r.tag  = TAG_NESTED;
            exp_q.push_back(r);
        end else begin
            exp_err = 1'b1;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            exp_q.delete();
            exp_err = 1'b0;
        end else begin
            exp_err = 1'b0;
            if (exp_q.size() == 0) begin
                if (cmd_valid) model_accept();
            end else if (sw_done) begin
                void'(exp_q.pop_front());
            end
        end
        if (cyc > 150000 && !finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog R8 actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    // Compare on every falling edge, then drive a new completion bit
    always @(negedge clk) begin
        if (!rst) begin
            chk(cmd_ready === (exp_q.size() == 0), "R1 ready", 64'(cmd_ready),
                64'(exp_q.size() == 0));
            chk(sw_valid === (exp_q.size() != 0), "R8 sweep valid", 64'(sw_valid),
                64'(exp_q.size() != 0));
            chk(cmd_err === exp_err, "R5 error pulse", 64'(cmd_err), 64'(exp_err));
            if (exp_q.size() != 0) begin
                chk(sw_tag === exp_q[0].tag, "R2 R3 R4 R6 tag", 64'(sw_tag),
                    64'(exp_q[0].tag));
                chk(sw_mask === exp_q[0].mask, "R3 R4 R6 mask", 64'(sw_mask),
                    64'(exp_q[0].mask));
                chk(sw_gscid === exp_q[0].gscid, "R7 guest operand", 64'(sw_gscid),
                    64'(exp_q[0].gscid));
                chk(sw_pscid === exp_q[0].pscid, "R7 process operand", 64'(sw_pscid),
                    64'(exp_q[0].pscid));
                chk(sw_addr === exp_q[0].addr, "R7 address", sw_addr, exp_q[0].addr);
            end
        end
        lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        sw_done = lfsr[0] | lfsr[7];
    end

    task automatic issue(input logic [63:0] w0, input logic [63:0] w1);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_dw0   = w0;
        cmd_dw1   = w1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cmd_ready === 1'b1, "R1 reset ready", 64'(cmd_ready), 64'd1);
        chk(sw_valid === 1'b0, "R1 reset valid", 64'(sw_valid), 64'd0);
        chk(cmd_err === 1'b0, "R1 reset err", 64'(cmd_err), 64'd0);
        @(posedge clk);
        rst = 1'b0;

        // Directed: every flag combination, both function codes (R3 R4 R5 R6)
        for (int fn = 0; fn < 2; fn++) begin
            for (int fl = 0; fl < 8; fl++) begin
                issue({16'h0, 16'h1234 + 16'(fl), 20'hABCDE - 20'(fl), 6'h0,
                       3'(fl), 3'(fn)}, 64'hFFFF_FFFF_FFFF_FFFF - 64'(fl * 977));
            end
        end
        // Unknown function codes (R5)
        issue(64'h0000_5555_0000_0002, 64'h1);
        issue(64'h0000_5555_0000_003F, 64'h2);

        // Random commands, mostly legal codes, held back-to-back
        for (int i = 0; i < 300; i++) begin
            logic [63:0] w0;
            logic [2:0]  fsel;
            w0   = {$urandom, $urandom};
            fsel = (i % 7 == 6) ? 3'(4 + (i % 4)) : 3'(i % 2);
            w0[2:0] = fsel;
            issue(w0, {$urandom, $urandom});
        end

        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1;
            summary();
            $finish;
        end
    end

endmodule